// File: doc/BRIEF.md
# Virtual Interrupt List-Register Controller

This block is a small virtual interrupt CPU interface built around four list-register slots. A hypervisor-side port loads, clears and reads back the slots. Each slot holds a 10-bit interrupt ID, a 5-bit priority and a 2-bit state. A guest-side port offers two accesses. An acknowledge picks the most urgent pending interrupt and makes it active. An end-of-interrupt write retires an interrupt by ID.

The block keeps a bitmap of active priorities, one bit for each of 32 levels. The running priority is the most urgent set bit, or 32 when the bitmap is empty. A guest may complete an interrupt that the hypervisor has already spilled out of the slots. Such an end-of-interrupt still drops the running priority and is counted in a saturating miss counter. The hypervisor can then tell which spilled interrupt completed by using priority order alone. A registered maintenance interrupt reports a nonzero miss count when notification is enabled.

Top module: `vlr_ctrl`

## Requirements
- R1: After reset, every slot is invalid (state 2'b00), `run_pri` is 32, `miss_cnt` is 0, `maint_irq` is 0 and `gt_ack_id` is 1023.
- R2: State codes are 00 invalid, 01 pending, 10 active and 11 pending-and-active. A hypervisor write (`hv_we`) loads ID, priority and state into slot `hv_idx` at the next edge. A clear (`hv_clr`) makes that slot invalid. A write wins over a clear, and either one wins over a guest update to the same slot in the same cycle. A guest access in that cycle sees the old slot contents. The `hv_rd_*` outputs show slot `hv_rd_idx` combinationally.
- R3: Lower priority values are more urgent. On an acknowledge, the block chooses among slots in state pending whose priority value is strictly below `run_pri`. It picks the lowest value, and on a tie the lowest slot index. The chosen slot becomes active, and its ID appears on `gt_ack_id` after the edge. `gt_ack_id` holds until the next acknowledge.
- R4: If no slot qualifies, the acknowledge returns 1023 and changes no slot and no priority. ID 1023 is reserved and must not be loaded into a slot.
- R5: An acknowledge that picks an interrupt sets that interrupt's priority bit. `run_pri` always equals the lowest set bit, so nested acknowledges stack.
- R6: An end-of-interrupt whose ID matches an active slot (the lowest such index) changes that slot as follows: active becomes invalid, and pending-and-active becomes pending. `miss_cnt` does not change.
- R7: An end-of-interrupt whose ID is held by no non-invalid slot increments `miss_cnt`, which saturates at 31.
- R8: Every end-of-interrupt, whether it hits or misses, clears the lowest set bit of the active-priority bitmap. When the bitmap is empty, `run_pri` reads 32.
- R9: `maint_irq` is registered. After each edge it equals the value of `hv_miss_en` AND (`miss_cnt` != 0) from before that edge.
- R10: `hv_cnt_clr` zeroes `miss_cnt` at the next edge and takes precedence over a miss in the same cycle.
- R11: If an acknowledge and an end-of-interrupt arrive together, only the end-of-interrupt is processed and the acknowledge returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_we | input | 1 | Hypervisor slot write strobe |
| hv_clr | input | 1 | Hypervisor slot clear strobe |
| hv_idx | input | 2 | Slot targeted by write or clear |
| hv_wr_id | input | 10 | Interrupt ID to load |
| hv_wr_pri | input | 5 | Priority to load |
| hv_wr_state | input | 2 | State to load |
| hv_rd_idx | input | 2 | Slot shown on read outputs |
| hv_rd_id | output | 10 | ID of the read slot |
| hv_rd_pri | output | 5 | Priority of the read slot |
| hv_rd_state | output | 2 | State of the read slot |
| hv_cnt_clr | input | 1 | Clear the miss counter |
| hv_miss_en | input | 1 | Miss notification enable |
| gt_ack_req | input | 1 | Guest acknowledge strobe |
| gt_ack_id | output | 10 | Result of the last acknowledge |
| gt_eoi_req | input | 1 | Guest end-of-interrupt strobe |
| gt_eoi_id | input | 10 | ID being completed |
| run_pri | output | 6 | Running priority, 32 when idle |
| miss_cnt | output | 5 | Unmatched end-of-interrupt count |
| maint_irq | output | 1 | Maintenance interrupt |

## Verification
The slot contents, `gt_ack_id`, `run_pri` and `miss_cnt` all change at the first edge that samples a strobe. `maint_irq` follows the counter and the enable one edge later, and the slot read port is combinational. The bench drives each stimulus for exactly one edge and predicts the post-edge state from the pre-edge model. It samples 1 ns after that edge, stepping `hv_rd_idx` through every slot. The model's maintenance bit is formed from the pre-edge counter, so the checks match the one-cycle lag.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
    localparam int NSLOT = 4;
    localparam int ID_W  = 10;
    localparam int PRI_W = 5;
    localparam int CNT_W = 5;
    localparam int NLVL  = 1 << PRI_W;
    localparam int IDX_W = $clog2(NSLOT);
    localparam int RP_W  = PRI_W + 1;

    localparam logic [ID_W-1:0] SPUR_ID  = '1;
    localparam logic [RP_W-1:0] IDLE_PRI = RP_W'(NLVL);

    typedef enum logic [1:0] {
        ST_INV  = 2'b00,
        ST_PEND = 2'b01,
        ST_ACT  = 2'b10,
        ST_BOTH = 2'b11
    } lr_state_e;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [PRI_W-1:0] pri;
        lr_state_e        st;
    } lr_slot_t;

    // Most urgent (lowest) set level, or IDLE_PRI if none.
    function automatic logic [RP_W-1:0] top_level(input logic [NLVL-1:0] map);
        logic [RP_W-1:0] r;
        r = IDLE_PRI;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (map[i]) r = RP_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/vlr_slot_bank.sv
module vlr_slot_bank
    import vlr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   hv_we,
    input  logic                   hv_clr,
    input  logic [IDX_W-1:0]       hv_idx,
    input  lr_slot_t               hv_wdata,
    input  logic                   ack_fire,
    input  logic [IDX_W-1:0]       ack_idx,
    input  logic                   eoi_hit,
    input  logic [IDX_W-1:0]       eoi_idx,
    output lr_slot_t [NSLOT-1:0]   slots
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic sel_hv, sel_ack, sel_eoi;
        assign sel_hv  = (hv_idx  == IDX_W'(g));
        assign sel_ack = ack_fire && (ack_idx == IDX_W'(g));
        assign sel_eoi = eoi_hit  && (eoi_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '{id: '0, pri: '0, st: ST_INV};
            end else if (hv_we && sel_hv) begin
                slots[g] <= hv_wdata;
            end else if (hv_clr && sel_hv) begin
                slots[g].st <= ST_INV;
            end else if (sel_ack) begin
                slots[g].st <= ST_ACT;
            end else if (sel_eoi) begin
                slots[g].st <= (slots[g].st == ST_BOTH) ? ST_PEND : ST_INV;
            end
        end
    end
endmodule

// File: rtl/vlr_arbiter.sv
module vlr_arbiter
    import vlr_pkg::*;
(
    input  lr_slot_t [NSLOT-1:0]   slots,
    input  logic [RP_W-1:0]        run_pri,
    input  logic [ID_W-1:0]        eoi_id,
    output logic                   ack_found,
    output logic [IDX_W-1:0]       ack_idx,
    output logic [PRI_W-1:0]       ack_pri,
    output logic [ID_W-1:0]        ack_id,
    output logic                   eoi_hit,
    output logic [IDX_W-1:0]       eoi_idx,
    output logic                   eoi_known
);
    logic [RP_W-1:0] best;

    always_comb begin
        best      = run_pri;
        ack_found = 1'b0;
        ack_idx   = '0;
        ack_pri   = '0;
        ack_id    = SPUR_ID;
        eoi_hit   = 1'b0;
        eoi_idx   = '0;
        eoi_known = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slots[i].st == ST_PEND && {1'b0, slots[i].pri} < best) begin
                best      = {1'b0, slots[i].pri};
                ack_found = 1'b1;
                ack_idx   = IDX_W'(i);
                ack_pri   = slots[i].pri;
                ack_id    = slots[i].id;
            end
            if (slots[i].st != ST_INV && slots[i].id == eoi_id) begin
                eoi_known = 1'b1;
                if (!eoi_hit && slots[i].st[1]) begin
                    eoi_hit = 1'b1;
                    eoi_idx = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/vlr_prio_stack.sv
module vlr_prio_stack
    import vlr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [PRI_W-1:0]  push_pri,
    input  logic              drop,
    output logic [RP_W-1:0]   run_pri
);
    logic [NLVL-1:0] map_q, map_d;

    assign run_pri = top_level(map_q);

    always_comb begin
        map_d = map_q;
        if (drop && run_pri != IDLE_PRI) map_d[run_pri[PRI_W-1:0]] = 1'b0;
        if (push) map_d[push_pri] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= '0;
        else     map_q <= map_d;
    end
endmodule

// File: rtl/vlr_miss_ctr.sv
module vlr_miss_ctr
    import vlr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miss,
    input  logic              clr,
    input  logic              en,
    output logic [CNT_W-1:0]  cnt,
    output logic              maint
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            maint <= 1'b0;
        end else begin
            maint <= en && (cnt != '0);
            if (clr)                    cnt <= '0;
            else if (miss && cnt != '1) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vlr_ctrl.sv
module vlr_ctrl
    import vlr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hv_we,
    input  logic              hv_clr,
    input  logic [1:0]        hv_idx,
    input  logic [9:0]        hv_wr_id,
    input  logic [4:0]        hv_wr_pri,
    input  logic [1:0]        hv_wr_state,
    input  logic [1:0]        hv_rd_idx,
    output logic [9:0]        hv_rd_id,
    output logic [4:0]        hv_rd_pri,
    output logic [1:0]        hv_rd_state,
    input  logic              hv_cnt_clr,
    input  logic              hv_miss_en,
    input  logic              gt_ack_req,
    output logic [9:0]        gt_ack_id,
    input  logic              gt_eoi_req,
    input  logic [9:0]        gt_eoi_id,
    output logic [5:0]        run_pri,
    output logic [4:0]        miss_cnt,
    output logic              maint_irq
);
    lr_slot_t [NSLOT-1:0] slots;
    lr_slot_t             wdata;
    logic                 ack_found, ack_fire, eoi_hit, eoi_known;
    logic [IDX_W-1:0]     ack_idx, eoi_idx;
    logic [PRI_W-1:0]     ack_pri;
    logic [ID_W-1:0]      ack_id_c;

    assign wdata    = '{id: hv_wr_id, pri: hv_wr_pri, st: lr_state_e'(hv_wr_state)};
    assign ack_fire = gt_ack_req && !gt_eoi_req && ack_found;

    vlr_slot_bank u_bank (
        .clk(clk), .rst(rst), .hv_we(hv_we), .hv_clr(hv_clr), .hv_idx(hv_idx),
        .hv_wdata(wdata), .ack_fire(ack_fire), .ack_idx(ack_idx),
        .eoi_hit(gt_eoi_req && eoi_hit), .eoi_idx(eoi_idx), .slots(slots)
    );

    vlr_arbiter u_arb (
        .slots(slots), .run_pri(run_pri), .eoi_id(gt_eoi_id),
        .ack_found(ack_found), .ack_idx(ack_idx), .ack_pri(ack_pri), .ack_id(ack_id_c),
        .eoi_hit(eoi_hit), .eoi_idx(eoi_idx), .eoi_known(eoi_known)
    );

    vlr_prio_stack u_prio (
        .clk(clk), .rst(rst), .push(ack_fire), .push_pri(ack_pri),
        .drop(gt_eoi_req), .run_pri(run_pri)
    );

    vlr_miss_ctr u_miss (
        .clk(clk), .rst(rst), .miss(gt_eoi_req && !eoi_known), .clr(hv_cnt_clr),
        .en(hv_miss_en), .cnt(miss_cnt), .maint(maint_irq)
    );

    always_ff @(posedge clk) begin
        if (rst)             gt_ack_id <= SPUR_ID;
        else if (gt_ack_req) gt_ack_id <= ack_fire ? ack_id_c : SPUR_ID;
    end

    assign hv_rd_id    = slots[hv_rd_idx].id;
    assign hv_rd_pri   = slots[hv_rd_idx].pri;
    assign hv_rd_state = slots[hv_rd_idx].st;
endmodule

// File: rtl/vlr_ctrl_chk.sv
module vlr_ctrl_chk
    import vlr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              gt_ack_req,
    input logic              gt_eoi_req,
    input logic [ID_W-1:0]   gt_ack_id,
    input logic [RP_W-1:0]   run_pri,
    input logic [CNT_W-1:0]  miss_cnt,
    input logic              maint_irq,
    input logic              hv_miss_en,
    input logic              hv_cnt_clr,
    input logic              eoi_known
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    a_r3_ack_raises_pri: assert property (@(posedge clk) disable iff (rst)
        (gt_ack_req && !gt_eoi_req) |=> (gt_ack_id == SPUR_ID) || (run_pri < $past(run_pri)));

    a_r4_spurious_keeps_pri: assert property (@(posedge clk) disable iff (rst)
        (gt_ack_req && !gt_eoi_req) |=> (gt_ack_id != SPUR_ID) || $stable(run_pri));

    a_r7_miss_counts: assert property (@(posedge clk) disable iff (rst)
        (gt_eoi_req && !eoi_known && !hv_cnt_clr && miss_cnt != '1)
        |=> miss_cnt == $past(miss_cnt) + ONE);

    a_r7_no_decrease: assert property (@(posedge clk) disable iff (rst)
        !hv_cnt_clr |=> miss_cnt >= $past(miss_cnt));

    a_r8_eoi_drops_pri: assert property (@(posedge clk) disable iff (rst)
        gt_eoi_req |=> (run_pri > $past(run_pri)) || ($past(run_pri) == IDLE_PRI));

    a_r9_maint_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> maint_irq == $past(hv_miss_en && miss_cnt != '0));

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
        hv_cnt_clr |=> miss_cnt == '0);

    a_r11_collision_spurious: assert property (@(posedge clk) disable iff (rst)
        (gt_ack_req && gt_eoi_req) |=> gt_ack_id == SPUR_ID);
endmodule

bind vlr_ctrl vlr_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .gt_ack_req(gt_ack_req), .gt_eoi_req(gt_eoi_req),
    .gt_ack_id(gt_ack_id), .run_pri(run_pri), .miss_cnt(miss_cnt),
    .maint_irq(maint_irq), .hv_miss_en(hv_miss_en), .hv_cnt_clr(hv_cnt_clr),
    .eoi_known(eoi_known)
);

// File: tb/sim_vlr_ctrl.sv
module sim_vlr_ctrl;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, hv_we, hv_clr, hv_cnt_clr, hv_miss_en, gt_ack_req, gt_eoi_req, maint_irq;
    logic [1:0] hv_idx, hv_wr_state, hv_rd_idx, hv_rd_state;
    logic [9:0] hv_wr_id, hv_rd_id, gt_ack_id, gt_eoi_id;
    logic [4:0] hv_wr_pri, hv_rd_pri, miss_cnt;
    logic [5:0] run_pri;

    vlr_ctrl u0 (.*);

    int n_cmp = 0, n_bad = 0;
    logic [9:0]  m_id  [4];
    logic [4:0]  m_pri [4];
    logic [1:0]  m_st  [4];
    logic [31:0] m_map;
    int          m_cnt;
    logic        m_maint;
    logic [9:0]  m_ack;

    function automatic int m_rpr();
        for (int i = 0; i < 32; i++) if (m_map[i]) return i;
        return 32;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        cmp({tag, "/R5"}, "run_pri", int'(run_pri), m_rpr());
        cmp({tag, "/R7"}, "miss_cnt", int'(miss_cnt), m_cnt);
        cmp({tag, "/R9"}, "maint_irq", int'(maint_irq), int'(m_maint));
        cmp({tag, "/R3"}, "ack_id", int'(gt_ack_id), int'(m_ack));
        for (int i = 0; i < 4; i++) begin
            hv_rd_idx = 2'(i);
            #1;
            cmp({tag, "/R6"}, "slot state", int'(hv_rd_state), int'(m_st[i]));
            if (m_st[i] != 2'b00) begin
                cmp({tag, "/R2"}, "slot id", int'(hv_rd_id), int'(m_id[i]));
                cmp({tag, "/R2"}, "slot pri", int'(hv_rd_pri), int'(m_pri[i]));
            end
        end
    endtask

    // Inputs are already driven; predict, clock once, compare, release strobes.
    task automatic cycle(string tag);
        int rp, best, bidx, hidx, nc;
        bit known, ackv;
        logic [1:0] nst [4];
        logic [31:0] nmap;
        rp = m_rpr(); best = rp; bidx = -1; hidx = -1; known = 0;
        ackv = gt_ack_req && !gt_eoi_req;
        for (int i = 0; i < 4; i++) begin
            nst[i] = m_st[i];
            if (m_st[i] == 2'b01 && int'(m_pri[i]) < best) begin best = int'(m_pri[i]); bidx = i; end
            if (m_st[i] != 2'b00 && m_id[i] == gt_eoi_id) begin
                known = 1;
                if (hidx < 0 && m_st[i][1]) hidx = i;
            end
        end
        if (!ackv) bidx = -1;
        nmap = m_map;
        if (gt_eoi_req && rp < 32) nmap[rp] = 1'b0;
        if (bidx >= 0) begin nmap[m_pri[bidx]] = 1'b1; nst[bidx] = 2'b10; end
        if (gt_eoi_req && hidx >= 0) nst[hidx] = (m_st[hidx] == 2'b11) ? 2'b01 : 2'b00;
        nc = m_cnt;
        if (hv_cnt_clr) nc = 0;
        else if (gt_eoi_req && !known && nc < 31) nc++;
        @(posedge clk);
        m_maint = hv_miss_en && (m_cnt != 0);
        if (gt_ack_req) m_ack = (bidx >= 0) ? m_id[bidx] : 10'd1023;
        m_cnt = nc; m_map = nmap;
        for (int i = 0; i < 4; i++) m_st[i] = nst[i];
        if (hv_we) begin
            m_id[hv_idx] = hv_wr_id; m_pri[hv_idx] = hv_wr_pri; m_st[hv_idx] = hv_wr_state;
        end else if (hv_clr) m_st[hv_idx] = 2'b00;
        #1;
        check_all(tag);
        hv_we = 0; hv_clr = 0; hv_cnt_clr = 0; gt_ack_req = 0; gt_eoi_req = 0;
    endtask

    task automatic wr(int idx, int id, int pri, int st);
        hv_we = 1; hv_idx = 2'(idx); hv_wr_id = 10'(id); hv_wr_pri = 5'(pri); hv_wr_state = 2'(st);
        cycle("R2");
    endtask
    task automatic ack(string tag);
        gt_ack_req = 1; cycle(tag);
    endtask
    task automatic eoi(string tag, int id);
        gt_eoi_req = 1; gt_eoi_id = 10'(id); cycle(tag);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; hv_we = 0; hv_clr = 0; hv_idx = 0; hv_wr_id = 0; hv_wr_pri = 0; hv_wr_state = 0;
        hv_rd_idx = 0; hv_cnt_clr = 0; hv_miss_en = 0; gt_ack_req = 0; gt_eoi_req = 0; gt_eoi_id = 0;
        for (int i = 0; i < 4; i++) begin m_id[i] = 0; m_pri[i] = 0; m_st[i] = 0; end
        m_map = 0; m_cnt = 0; m_maint = 0; m_ack = 10'd1023;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check_all("R1");

        // R4: nothing pending -> spurious
        ack("R4");
        cmp("R4", "spurious id", int'(gt_ack_id), 1023);

        // Nested arrival with spills, then completions (R5, R6, R7, R8, R9)
        hv_miss_en = 1;
        wr(0, 10, 8, 1); ack("R5");
        wr(1, 11, 7, 1); ack("R5");
        wr(0, 12, 6, 1); ack("R5");
        wr(1, 13, 5, 1); ack("R5");
        cmp("R5", "stacked run_pri", int'(run_pri), 5);
        eoi("R6", 13); eoi("R6", 12);
        cmp("R6", "count after hits", int'(miss_cnt), 0);
        eoi("R8", 11);
        cmp("R7", "count after spilled eoi", int'(miss_cnt), 1);
        cmp("R8", "run_pri back to A", int'(run_pri), 8);
        eoi("R8", 10);
        cmp("R8", "idle run_pri", int'(run_pri), 32);
        cmp("R9", "maint asserted", int'(maint_irq), 1);

        // R7 saturation
        for (int k = 0; k < 35; k++) eoi("R7", 900);
        cmp("R7", "saturated", int'(miss_cnt), 31);
        // R10 clear wins over a simultaneous miss
        hv_cnt_clr = 1; eoi("R10", 901);
        cmp("R10", "cleared", int'(miss_cnt), 0);
        cycle("R9");
        cmp("R9", "maint low", int'(maint_irq), 0);

        // R3 tie: lowest index wins; strict eligibility
        wr(2, 20, 4, 1); wr(1, 21, 4, 1);
        ack("R3");
        cmp("R3", "tie winner", int'(gt_ack_id), 21);
        ack("R3");
        cmp("R3", "equal pri blocked", int'(gt_ack_id), 1023);
        // R11 collision
        gt_ack_req = 1; eoi("R11", 21);
        cmp("R11", "collision ack", int'(gt_ack_id), 1023);
        // R2 write beats ack on same slot
        wr(3, 30, 1, 1);
        hv_we = 1; hv_idx = 3; hv_wr_id = 31; hv_wr_pri = 2; hv_wr_state = 1; gt_ack_req = 1;
        cycle("R2");
        cmp("R2", "write wins state", int'(m_st[3]), 1);
        // R6 pending-and-active goes back to pending
        wr(0, 40, 3, 3); eoi("R6", 40);

        // Random traffic
        for (int it = 0; it < 3000; it++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 3) begin
                hv_we = 1; hv_idx = 2'($urandom); hv_wr_id = 10'($urandom % 8);
                hv_wr_pri = 5'($urandom); hv_wr_state = ($urandom % 3 == 0) ? 2'($urandom) : 2'b01;
            end else if (r == 3) begin
                hv_clr = 1; hv_idx = 2'($urandom);
            end
            gt_ack_req = ($urandom % 3 == 0);
            gt_eoi_req = ($urandom % 4 == 0);
            gt_eoi_id  = 10'($urandom % 10);
            hv_cnt_clr = ($urandom % 40 == 0);
            if ($urandom % 25 == 0) hv_miss_en = ~hv_miss_en;
            cycle("RND");
        end
        summary();
    end
endmodule